// File: doc/BRIEF.md
# Circuit Setup Configuration Unit

This unit sits in each router of a 4x4 mesh and serves the narrow setup network that builds circuits on several independent circuit planes. Each of the five router ports (local, north, south, east, west) delivers six-bit setup flits. A flit names a circuit plane and a destination node. The unit buffers each flit in a small per-port queue and picks its output port with XY dimension-ordered routing. It sends the flit on toward the next hop and records, for that plane, which input now feeds that output. The data path reads this configuration table to steer circuit flits through the crossbar without arbitration.

Setup is never refused. If the requested output of a plane is already held by another circuit, the new request takes it over. The unit pulses an invalidate on that output, naming the input whose circuit was torn down, so the data path can retire it. Data flits travel alongside setup, so no acknowledgement is returned. Only the low bits of the plane field that are needed to index the configured number of planes (2 or 4) select a table row.

Each input queue is a three-state machine. EMPTY moves to ONE on a push. ONE moves to TWO on a push without a pop, falls back to EMPTY on a pop without a push, and stays in ONE when a push and a pop come together or when neither happens. TWO moves to ONE on a pop; because the queue refuses pushes while in TWO, it otherwise stays in TWO. For each output, a fixed-priority arbiter grants one queue head per cycle. The lowest input index wins.

Top module: `circuit_setup_unit`

## Requirements
- R1: After reset every in_rdy bit is 1, and every out_vld, inv_vld and cfg_valid bit is 0.
- R2: A flit is {plane[5:4], dest[3:0]}, and ports are numbered 0 local, 1 north, 2 south, 3 east, 4 west. Node coordinates are x = id[1:0] and y = id[3:2], with y growing southward. A flit goes east if the destination x is larger than this node's x, and west if it is smaller. If the x values are equal, it goes south if the destination y is larger, north if it is smaller, and local if the y values are equal too.
- R3: If a flit is accepted at a clock edge and meets no contention, it is forwarded at the next edge. It appears on its output for exactly one cycle, with plane and dest unchanged.
- R4: At the edge that forwards a flit, table entry e = p*5 + o becomes valid. Here p is the plane modulo NPLANES and o is the output. cfg_valid[e] is set, and cfg_inport[3e+2:3e] holds the input index.
- R5: When that entry was already valid with a different input, inv_vld[o] pulses in the same cycle as the forward. inv_port[3o+2:3o] then carries the old input, and inv_plane[2o+1:2o] carries the plane. No pulse is given when the entry was empty or held the same input.
- R6: Entries of different planes on the same output are independent.
- R7: Flits that contend for one output are served in ascending input index. A loser waits in its queue and is forwarded in a later cycle, never dropped.
- R8: Each input holds at most two flits. in_rdy is 0 exactly while two are held, and flits leave an input in arrival order.
- R9: The table entries of an output change only in a cycle in which that output forwards a flit.
- R10: Flits bound for different outputs are forwarded in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 5 | Setup flit present, per input port |
| in_flit | input | 30 | Setup flits, 6 bits per input port |
| in_rdy | output | 5 | Input queue can accept a flit |
| out_vld | output | 5 | Forwarded flit present, per output port |
| out_flit | output | 30 | Forwarded flits, 6 bits per output port |
| cfg_valid | output | NPLANES*5 | Circuit entry held, per plane and output |
| cfg_inport | output | NPLANES*15 | Input index feeding each entry |
| inv_vld | output | 5 | Circuit on this output was torn down |
| inv_plane | output | 10 | Plane of the torn-down circuit |
| inv_port | output | 15 | Input of the torn-down circuit |

## Verification
On a single output, arbitration loss and circuit takeover land in the same cycle. The bench provokes this by presenting two flits of one plane at once for the same output. The winner is forwarded first. The loser follows in the next cycle and displaces the winner's entry, so its forward must carry an invalidate that names the winner's input. The scoreboard judges the order of forwards, their fields and the invalidate together, and table reads after each burst confirm the final owner. A second provocation sends flits to two different outputs in one cycle, and the test expects both forwards at the same edge.

// File: rtl/csu_pkg.sv
package csu_pkg;
    localparam int NPORT      = 5;
    localparam int PORT_W     = 3;
    localparam int PLANE_ID_W = 2;
    localparam int NODE_W     = 4;
    localparam int FLIT_W     = PLANE_ID_W + NODE_W;

    localparam logic [PORT_W-1:0] PORT_LOCAL = 3'd0;
    localparam logic [PORT_W-1:0] PORT_NORTH = 3'd1;
    localparam logic [PORT_W-1:0] PORT_SOUTH = 3'd2;
    localparam logic [PORT_W-1:0] PORT_EAST  = 3'd3;
    localparam logic [PORT_W-1:0] PORT_WEST  = 3'd4;

    typedef struct packed {
        logic [PLANE_ID_W-1:0] plane;
        logic [NODE_W-1:0]     dest;
    } setup_flit_t;

    typedef enum logic [1:0] {
        FQ_EMPTY = 2'd0,
        FQ_ONE   = 2'd1,
        FQ_TWO   = 2'd2
    } fq_state_e;

    // XY dimension order: resolve x first, then y; y grows southward
    function automatic logic [PORT_W-1:0] xy_route(
        input logic [NODE_W-1:0] here,
        input logic [NODE_W-1:0] dest
    );
        logic [PORT_W-1:0] r;
        if (dest[1:0] > here[1:0])      r = PORT_EAST;
        else if (dest[1:0] < here[1:0]) r = PORT_WEST;
        else if (dest[3:2] > here[3:2]) r = PORT_SOUTH;
        else if (dest[3:2] < here[3:2]) r = PORT_NORTH;
        else                            r = PORT_LOCAL;
        return r;
    endfunction
endpackage

// File: rtl/csu_setup_fifo.sv
module csu_setup_fifo
    import csu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        push_vld,
    input  setup_flit_t push_flit,
    output logic        push_rdy,
    input  logic        pop,
    output logic        head_vld,
    output setup_flit_t head_flit
);
    fq_state_e   state_q, state_d;
    setup_flit_t slot0_q, slot1_q;
    logic        do_push;

    assign do_push = push_vld && (state_q != FQ_TWO);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FQ_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FQ_EMPTY: if (do_push) state_d = FQ_ONE;
            FQ_ONE: begin
                if (do_push && !pop)      state_d = FQ_TWO;
                else if (!do_push && pop) state_d = FQ_EMPTY;
            end
            FQ_TWO:   if (pop) state_d = FQ_ONE;
            default:  state_d = FQ_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot0_q <= '0;
            slot1_q <= '0;
        end else begin
            unique case (state_q)
                FQ_EMPTY: if (do_push) slot0_q <= push_flit;
                FQ_ONE: begin
                    if (do_push && pop) slot0_q <= push_flit;
                    else if (do_push)   slot1_q <= push_flit;
                end
                FQ_TWO:   if (pop) slot0_q <= slot1_q;
                default: ;
            endcase
        end
    end

    always_comb begin
        head_vld  = (state_q != FQ_EMPTY);
        push_rdy  = (state_q != FQ_TWO);
        head_flit = slot0_q;
    end
endmodule

// File: rtl/csu_xy_route.sv
module csu_xy_route
    import csu_pkg::*;
#(
    parameter logic [3:0] NODE_ID = 4'h5
) (
    input  logic              vld,
    input  setup_flit_t       flit,
    output logic [NPORT-1:0]  req_oh
);
    logic [PORT_W-1:0] dir;

    always_comb begin
        dir    = xy_route(NODE_ID, flit.dest);
        req_oh = '0;
        for (int o = 0; o < NPORT; o++) begin
            if (vld && (dir == PORT_W'(o))) req_oh[o] = 1'b1;
        end
    end
endmodule

// File: rtl/csu_fixed_arb.sv
module csu_fixed_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic taken;
        taken = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !taken) begin
                gnt[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/csu_cfg_table.sv
module csu_cfg_table
    import csu_pkg::*;
#(
    parameter int NPLANES = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NPORT-1:0]               wr_en,
    input  logic [NPORT*PLANE_ID_W-1:0]    wr_plane,
    input  logic [NPORT*PORT_W-1:0]        wr_src,
    output logic [NPLANES*NPORT-1:0]       cfg_valid,
    output logic [NPLANES*NPORT*PORT_W-1:0] cfg_inport,
    output logic [NPORT-1:0]               inv_vld,
    output logic [NPORT*PLANE_ID_W-1:0]    inv_plane,
    output logic [NPORT*PORT_W-1:0]        inv_port
);
    localparam int PSEL_W = (NPLANES > 2) ? 2 : 1;

    logic              ent_vld_q [NPLANES][NPORT];
    logic [PORT_W-1:0] ent_src_q [NPLANES][NPORT];
    logic [PSEL_W-1:0] psel      [NPORT];
    logic [NPORT-1:0]  displace;

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            psel[o]     = wr_plane[o*PLANE_ID_W +: PSEL_W];
            displace[o] = wr_en[o] && ent_vld_q[psel[o]][o]
                          && (ent_src_q[psel[o]][o] != wr_src[o*PORT_W +: PORT_W]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int p = 0; p < NPLANES; p++) begin
                for (int o = 0; o < NPORT; o++) begin
                    ent_vld_q[p][o] <= 1'b0;
                    ent_src_q[p][o] <= '0;
                end
            end
            inv_vld   <= '0;
            inv_plane <= '0;
            inv_port  <= '0;
        end else begin
            for (int o = 0; o < NPORT; o++) begin
                inv_vld[o] <= displace[o];
                if (displace[o]) begin
                    inv_plane[o*PLANE_ID_W +: PLANE_ID_W] <= wr_plane[o*PLANE_ID_W +: PLANE_ID_W];
                    inv_port[o*PORT_W +: PORT_W]          <= ent_src_q[psel[o]][o];
                end
                if (wr_en[o]) begin
                    ent_vld_q[psel[o]][o] <= 1'b1;
                    ent_src_q[psel[o]][o] <= wr_src[o*PORT_W +: PORT_W];
                end
            end
        end
    end

    for (genvar p = 0; p < NPLANES; p++) begin : g_pl
        for (genvar o = 0; o < NPORT; o++) begin : g_op
            assign cfg_valid[p*NPORT + o]                     = ent_vld_q[p][o];
            assign cfg_inport[(p*NPORT + o)*PORT_W +: PORT_W] = ent_src_q[p][o];
        end
    end
endmodule

// File: rtl/circuit_setup_unit.sv
module circuit_setup_unit
    import csu_pkg::*;
#(
    parameter logic [3:0] NODE_ID = 4'h5,
    parameter int         NPLANES = 4
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NPORT-1:0]                 in_vld,
    input  logic [NPORT*FLIT_W-1:0]          in_flit,
    output logic [NPORT-1:0]                 in_rdy,
    output logic [NPORT-1:0]                 out_vld,
    output logic [NPORT*FLIT_W-1:0]          out_flit,
    output logic [NPLANES*NPORT-1:0]         cfg_valid,
    output logic [NPLANES*NPORT*PORT_W-1:0]  cfg_inport,
    output logic [NPORT-1:0]                 inv_vld,
    output logic [NPORT*PLANE_ID_W-1:0]      inv_plane,
    output logic [NPORT*PORT_W-1:0]          inv_port
);
    setup_flit_t      head_flit [NPORT];
    logic [NPORT-1:0] head_vld;
    logic [NPORT-1:0] pop;
    logic [NPORT-1:0] route_oh  [NPORT];
    logic [NPORT-1:0] req_by_out [NPORT];
    logic [NPORT-1:0] gnt_by_out [NPORT];

    logic [NPORT-1:0]            fwd_en;
    setup_flit_t                 fwd_flit [NPORT];
    logic [NPORT*PLANE_ID_W-1:0] fwd_plane_flat;
    logic [NPORT*PORT_W-1:0]     fwd_src_flat;

    for (genvar i = 0; i < NPORT; i++) begin : g_in
        csu_setup_fifo u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_vld  (in_vld[i]),
            .push_flit (setup_flit_t'(in_flit[i*FLIT_W +: FLIT_W])),
            .push_rdy  (in_rdy[i]),
            .pop       (pop[i]),
            .head_vld  (head_vld[i]),
            .head_flit (head_flit[i])
        );
        csu_xy_route #(.NODE_ID(NODE_ID)) u_route (
            .vld    (head_vld[i]),
            .flit   (head_flit[i]),
            .req_oh (route_oh[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) req_by_out[o][i] = route_oh[i][o];
        end
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_out
        csu_fixed_arb #(.N(NPORT)) u_arb (
            .req (req_by_out[o]),
            .gnt (gnt_by_out[o])
        );
    end

    // Per output: winning flit and its input index
    always_comb begin
        pop = '0;
        for (int o = 0; o < NPORT; o++) begin
            fwd_en[o]   = |gnt_by_out[o];
            fwd_flit[o] = '0;
            fwd_src_flat[o*PORT_W +: PORT_W] = '0;
            for (int i = 0; i < NPORT; i++) begin
                if (gnt_by_out[o][i]) begin
                    fwd_flit[o] = head_flit[i];
                    fwd_src_flat[o*PORT_W +: PORT_W] = PORT_W'(i);
                    pop[i] = 1'b1;
                end
            end
            fwd_plane_flat[o*PLANE_ID_W +: PLANE_ID_W] = fwd_flit[o].plane;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld  <= '0;
            out_flit <= '0;
        end else begin
            out_vld <= fwd_en;
            for (int o = 0; o < NPORT; o++) begin
                if (fwd_en[o]) out_flit[o*FLIT_W +: FLIT_W] <= fwd_flit[o];
            end
        end
    end

    csu_cfg_table #(.NPLANES(NPLANES)) u_table (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (fwd_en),
        .wr_plane   (fwd_plane_flat),
        .wr_src     (fwd_src_flat),
        .cfg_valid  (cfg_valid),
        .cfg_inport (cfg_inport),
        .inv_vld    (inv_vld),
        .inv_plane  (inv_plane),
        .inv_port   (inv_port)
    );
endmodule

// File: rtl/csu_checker.sv
module csu_checker
    import csu_pkg::*;
#(
    parameter int NPLANES = 4
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic [NPORT-1:0]                 out_vld,
    input logic [NPORT*FLIT_W-1:0]          out_flit,
    input logic [NPLANES*NPORT-1:0]         cfg_valid,
    input logic [NPLANES*NPORT*PORT_W-1:0]  cfg_inport,
    input logic [NPORT-1:0]                 inv_vld,
    input logic [NPORT*PLANE_ID_W-1:0]      inv_plane,
    input logic [NPORT*PORT_W-1:0]          inv_port
);
    localparam int PSEL_W = (NPLANES > 2) ? 2 : 1;

    for (genvar o = 0; o < NPORT; o++) begin : g_o
        // R5: a takeover is always reported together with the forward
        p_inv_with_fwd_r5: assert property (@(posedge clk) disable iff (!rst_n)
            inv_vld[o] |-> out_vld[o]);

        for (genvar p = 0; p < NPLANES; p++) begin : g_p
            localparam int E = p*NPORT + o;

            // R4: a forwarded flit leaves its entry valid
            p_fwd_sets_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (out_vld[o] && (out_flit[o*FLIT_W + NODE_W +: PSEL_W] == PSEL_W'(p)))
                |-> cfg_valid[E]);

            // R5: the reported old input is what the entry held before
            p_inv_names_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (inv_vld[o] && (inv_plane[o*PLANE_ID_W +: PSEL_W] == PSEL_W'(p)))
                |-> ($past(cfg_valid[E])
                     && ($past(cfg_inport[E*PORT_W +: PORT_W]) == inv_port[o*PORT_W +: PORT_W])));

            // R9: entries of a silent output hold still
            p_cfg_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
                !out_vld[o] |-> ($stable(cfg_valid[E])
                                 && $stable(cfg_inport[E*PORT_W +: PORT_W])));
        end
    end
endmodule

bind circuit_setup_unit csu_checker #(.NPLANES(NPLANES)) u_csu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_vld    (out_vld),
    .out_flit   (out_flit),
    .cfg_valid  (cfg_valid),
    .cfg_inport (cfg_inport),
    .inv_vld    (inv_vld),
    .inv_plane  (inv_plane),
    .inv_port   (inv_port)
);

// File: tb/circuit_setup_unit_bench.sv
module circuit_setup_unit_bench;
    localparam int NP = 5;
    localparam int NPL = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NP-1:0]    in_vld = '0;
    logic [NP*6-1:0]  in_flit = '0;
    logic [NP-1:0]    in_rdy, out_vld, inv_vld;
    logic [NP*6-1:0]  out_flit;
    logic [NPL*NP-1:0]   cfg_valid;
    logic [NPL*NP*3-1:0] cfg_inport;
    logic [NP*2-1:0]  inv_plane;
    logic [NP*3-1:0]  inv_port;

    circuit_setup_unit #(.NODE_ID(4'h5), .NPLANES(NPL)) u_circuit_setup_unit (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_flit(in_flit), .in_rdy(in_rdy),
        .out_vld(out_vld), .out_flit(out_flit), .cfg_valid(cfg_valid),
        .cfg_inport(cfg_inport), .inv_vld(inv_vld), .inv_plane(inv_plane),
        .inv_port(inv_port)
    );

    always #10 clk = ~clk;

    typedef struct {
        int port; int plane; int dest; int inv; int old; string tag;
    } exp_t;

    exp_t expq[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   mon_on = 1'b0;
    bit   done = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_fwd(input int port, input int plane, input int dest,
                              input int inv, input int old, input string tag);
        exp_t e;
        e.port = port; e.plane = plane; e.dest = dest; e.inv = inv; e.old = old; e.tag = tag;
        expq.push_back(e);
    endtask

    task automatic set_in(input int i, input int plane, input int dest);
        in_vld[i] = 1'b1;
        in_flit[i*6 +: 6] = {2'(plane), 4'(dest)};
    endtask

    task automatic tick();
        @(negedge clk);
        in_vld = '0;
    endtask

    task automatic check_entry(input int p, input int o, input int vld, input int src,
                               input string tag);
        int e;
        e = p*NP + o;
        chk(cfg_valid[e] == 1'(vld), {tag, " entry valid"}, cfg_valid[e], vld);
        if (vld != 0)
            chk(cfg_inport[e*3 +: 3] == 3'(src), {tag, " entry input"}, cfg_inport[e*3 +: 3], src);
    endtask

    task automatic drain();
        for (int k = 0; k < 20 && expq.size() != 0; k++) @(negedge clk);
        chk(expq.size() == 0, "drain", expq.size(), 0);
        @(negedge clk);
    endtask

    // Monitor: pop one expectation per forwarded flit, ports scanned in ascending order
    always @(negedge clk) begin
        if (mon_on) begin
            for (int o = 0; o < NP; o++) begin
                if (out_vld[o]) begin
                    if (expq.size() == 0) begin
                        chk(1'b0, "unexpected forward", o, -1);
                    end else begin
                        exp_t e;
                        bit ok;
                        int act_inv, act_old;
                        e = expq.pop_front();
                        act_inv = inv_vld[o];
                        act_old = inv_port[o*3 +: 3];
                        ok = (o == e.port) && (out_flit[o*6 + 4 +: 2] == 2'(e.plane))
                             && (out_flit[o*6 +: 4] == 4'(e.dest)) && (act_inv == e.inv);
                        if (e.inv != 0)
                            ok = ok && (act_old == e.old)
                                 && (inv_plane[o*2 +: 2] == 2'(e.plane));
                        chk(ok, e.tag, o*10000 + int'(out_flit[o*6 +: 6])*10 + act_inv,
                            e.port*10000 + (e.plane*16 + e.dest)*10 + e.inv);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(in_rdy == '1, "R1 in_rdy", in_rdy, 31);
        chk(out_vld == '0, "R1 out_vld", out_vld, 0);
        chk(inv_vld == '0, "R1 inv_vld", inv_vld, 0);
        chk(cfg_valid == '0, "R1 cfg_valid", cfg_valid, 0);
        mon_on = 1'b1;

        // R2 R3: node (1,1); dest 7 = (3,1) goes east; exact timing
        expect_fwd(3, 0, 7, 0, 0, "R3 forward east");
        set_in(1, 0, 7);
        tick();
        chk(out_vld == '0, "R3 not before next edge", out_vld, 0);
        tick();
        chk(out_vld == 5'b01000, "R2 east port R3 timing", out_vld, 8);
        tick();
        chk(out_vld == '0, "R3 single cycle", out_vld, 0);
        check_entry(0, 3, 1, 1, "R4 plane0 east");

        // R5: takeover of plane 0 east by input 4 (dest 15 = (3,3), x first)
        expect_fwd(3, 0, 15, 1, 1, "R5 takeover east");
        set_in(4, 0, 15);
        tick(); drain();
        check_entry(0, 3, 1, 4, "R5 new owner");

        // R6 R9: plane 1 east, plane 0 entry untouched
        expect_fwd(3, 1, 7, 0, 0, "R6 plane1 east no inv");
        set_in(2, 1, 7);
        tick(); drain();
        check_entry(1, 3, 1, 2, "R6 plane1 entry");
        check_entry(0, 3, 1, 4, "R6 R9 plane0 kept");
        check_entry(0, 4, 0, 0, "R9 west untouched");

        // R7 + R5 same cycle: inputs 0 and 3 both west on plane 2
        expect_fwd(4, 2, 4, 0, 0, "R7 winner input0");
        expect_fwd(4, 2, 0, 1, 0, "R7 loser later R5 inv");
        set_in(0, 2, 4);
        set_in(3, 2, 0);
        tick(); drain();
        check_entry(2, 4, 1, 3, "R7 final owner");

        // R8: queue fills on input 1 while input 0 keeps south busy
        expect_fwd(2, 0, 13, 0, 0, "R8 i0 first");
        expect_fwd(2, 1, 13, 0, 0, "R8 i0 second");
        expect_fwd(2, 0, 13, 1, 0, "R8 i1 first");
        expect_fwd(2, 1, 13, 1, 0, "R8 i1 second");
        set_in(0, 0, 13); set_in(1, 0, 13);
        tick();
        set_in(0, 1, 13); set_in(1, 1, 13);
        tick();
        chk(in_rdy[1] == 1'b0, "R8 full input not ready", in_rdy[1], 0);
        chk(in_rdy[0] == 1'b1, "R8 draining input ready", in_rdy[0], 1);
        drain();
        chk(in_rdy == '1, "R8 ready after drain", in_rdy, 31);
        check_entry(0, 2, 1, 1, "R8 plane0 south");
        check_entry(1, 2, 1, 1, "R8 plane1 south");

        // R10 R2: local and north in the same cycle
        expect_fwd(0, 3, 5, 0, 0, "R10 local eject");
        expect_fwd(1, 3, 1, 0, 0, "R10 north same cycle");
        set_in(2, 3, 5);
        set_in(4, 3, 1);
        tick();
        tick();
        chk(out_vld == 5'b00011, "R10 both forwarded", out_vld, 3);
        drain();
        check_entry(3, 0, 1, 2, "R10 local entry");
        check_entry(3, 1, 1, 4, "R10 north entry");

        // R5: same input again on a held entry gives no invalidate
        expect_fwd(0, 3, 5, 0, 0, "R5 same input no inv");
        set_in(2, 3, 5);
        tick(); drain();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule